// File: doc/BRIEF.md
# Coprocessor Indirect Register Port

This block connects a host processor's register bus to the internal register file of an error-correction coprocessor. The host sees three registers, chosen by a 2-bit select: a command register, a pointer register and a data window. A write to the command register issues an operation to the coprocessor. The pointer picks one entry of the internal register file. Each access through the data window reaches the entry the pointer names and then advances the pointer, so the host can stream a block of registers with a single pointer setup.

Operations are decoded into one-cycle start strobes. Trellis-update work and traceback-only work are carried out elsewhere. Here they are stood in for by a busy interval of fixed length per operation. While busy is high, command writes and all data-window traffic are refused and `hostReady` drops so the host can retry. The pointer stays fully usable during that time, so the host can aim it at the first entry it wants to read once the result is ready. A reinitialise operation returns the register file to its power-up contents.

Top module: `ccpHostPort`

## Requirements
- R1: After `rstN` is low on a clock edge, the command register reads 0x0004, the pointer reads 0, `busy`, `done` and all strobes are low, `hostReady` is high, and the file entries read 0 except entry REG_COUNT-2 (0x00FF) and entry REG_COUNT-1 (0xFFFF).
- R2: Select encoding is 0 = command, 1 = pointer, 2 = data window, 3 = unused. A data-window write stores `hostWdata` into the entry named by the pointer. With select 2 and not busy, `hostRdata` shows that entry in the same cycle. The pointer reads back zero-extended.
- R3: Every accepted data-window read or write advances the pointer by one at the clock edge, and entry REG_COUNT-1 wraps to 0.
- R4: An accepted command write of 0x0000, 0x0001, 0x0002 or 0x0004 raises exactly one of `startMlse`, `startConv`, `startTrace` or `startReset`, respectively, for one cycle, in the cycle after the write.
- R5: A command write of any other code updates the command register but raises no strobe, no `busy` and no `done`.
- R6: `busy` is high from the cycle after an accepted operation write: 16 cycles for either update code, 8 for traceback, 1 for reinitialise. `done` is high for exactly the first cycle in which `busy` is low again.
- R7: The reinitialise operation restores every file entry to its R1 value and leaves the pointer unchanged.
- R8: While `busy` is high, command writes, data-window writes and data-window reads are refused. `hostReady` is low for them, a refused read returns 0, and no register changes, including the pointer.
- R9: While `busy` is high, the command register stays readable, and the pointer stays readable and writable with `hostReady` high.
- R10: A command write presented in the cycle where `done` is high is accepted and starts the next operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| hostSel | input | 2 | Register select: 0 command, 1 pointer, 2 data window |
| hostWr | input | 1 | Host write request |
| hostRd | input | 1 | Host read request |
| hostWdata | input | 16 | Host write data |
| hostRdata | output | 16 | Read data for the selected register (combinational) |
| hostReady | output | 1 | Low when the current access is refused |
| busy | output | 1 | Coprocessor operation in progress |
| done | output | 1 | One-cycle pulse when an operation finishes |
| startMlse | output | 1 | Start strobe, sequence-estimation update |
| startConv | output | 1 | Start strobe, convolutional update |
| startTrace | output | 1 | Start strobe, traceback only |
| startReset | output | 1 | Start strobe, reinitialise |

## Verification
Two events can land on the same edge: the host moving the pointer and an operation finishing. A pointer write is placed in the last busy cycle of a 16-cycle update. A new command is then issued in the very cycle `done` pulses. The test passes if the pointer keeps the value written under busy, the new traceback strobe appears one cycle later, and its busy interval has its full length. The remaining tests sweep all file entries through the wrapping pointer, walk every defined command and a spread of reserved codes, and issue every refused access type during an update.

// File: rtl/ccpPkg.sv
`timescale 1ns/1ps
package ccpPkg;
  localparam int DATA_W = 16;

  typedef enum logic [1:0] {
    SEL_INSTR = 2'd0,
    SEL_ADDR  = 2'd1,
    SEL_DATA  = 2'd2,
    SEL_NONE  = 2'd3
  } hostSel_e;

  localparam logic [DATA_W-1:0] OP_MLSE   = 16'h0000;
  localparam logic [DATA_W-1:0] OP_CONV   = 16'h0001;
  localparam logic [DATA_W-1:0] OP_TRACE  = 16'h0002;
  localparam logic [DATA_W-1:0] OP_REINIT = 16'h0004;
  localparam logic [DATA_W-1:0] INSTR_RST = 16'h0004;

  // strobes from control to datapath
  typedef struct packed {
    logic instrWr;
    logic ptrWr;
    logic dataWr;
    logic dataStep;
    logic fileReset;
  } ccpStrobe_t;
endpackage

// File: rtl/ccpCtrl.sv
`timescale 1ns/1ps
module ccpCtrl import ccpPkg::*; #(
  parameter int UPD_CYC   = 16,
  parameter int TRACE_CYC = 8,
  parameter int RST_CYC   = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        hostSel,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [DATA_W-1:0] hostWdata,
  output ccpStrobe_t        strb,
  output logic              hostReady,
  output logic              busy,
  output logic              done,
  output logic              startMlse,
  output logic              startConv,
  output logic              startTrace,
  output logic              startReset
);
  localparam int MAX_CYC = (UPD_CYC > TRACE_CYC) ?
                           ((UPD_CYC > RST_CYC) ? UPD_CYC : RST_CYC) :
                           ((TRACE_CYC > RST_CYC) ? TRACE_CYC : RST_CYC);
  localparam int CNT_W = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] UPD_LD   = CNT_W'(UPD_CYC - 1);
  localparam logic [CNT_W-1:0] TRACE_LD = CNT_W'(TRACE_CYC - 1);
  localparam logic [CNT_W-1:0] RST_LD   = CNT_W'(RST_CYC - 1);

  logic             busyQ, doneQ;
  logic [3:0]       startQ;   // {reinit, trace, conv, mlse}
  logic [CNT_W-1:0] cntQ;
  logic             selInstr, selAddr, selData;
  logic             wantInstrWr, wantData;
  logic             opValid;
  logic [3:0]       opVec;
  logic [CNT_W-1:0] opLoad;

  assign selInstr    = (hostSel == SEL_INSTR);
  assign selAddr     = (hostSel == SEL_ADDR);
  assign selData     = (hostSel == SEL_DATA);
  assign wantInstrWr = selInstr & hostWr;
  assign wantData    = selData & (hostWr | hostRd);
  assign hostReady   = !(busyQ & (wantInstrWr | wantData));

  assign strb.instrWr   = wantInstrWr & !busyQ;
  assign strb.ptrWr     = selAddr & hostWr;
  assign strb.dataWr    = selData & hostWr & !busyQ;
  assign strb.dataStep  = wantData & !busyQ;
  assign strb.fileReset = startQ[3];

  always_comb begin
    opValid = 1'b1;
    opVec   = 4'b0000;
    opLoad  = '0;
    case (hostWdata)
      OP_MLSE:   begin opVec = 4'b0001; opLoad = UPD_LD;   end
      OP_CONV:   begin opVec = 4'b0010; opLoad = UPD_LD;   end
      OP_TRACE:  begin opVec = 4'b0100; opLoad = TRACE_LD; end
      OP_REINIT: begin opVec = 4'b1000; opLoad = RST_LD;   end
      default:   opValid = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      doneQ  <= 1'b0;
      startQ <= '0;
      cntQ   <= '0;
    end else begin
      startQ <= '0;
      doneQ  <= 1'b0;
      if (strb.instrWr && opValid) begin
        busyQ  <= 1'b1;
        cntQ   <= opLoad;
        startQ <= opVec;
      end else if (busyQ) begin
        if (cntQ == '0) begin
          busyQ <= 1'b0;
          doneQ <= 1'b1;
        end else begin
          cntQ <= cntQ - 1'b1;
        end
      end
    end
  end

  assign busy       = busyQ;
  assign done       = doneQ;
  assign startMlse  = startQ[0];
  assign startConv  = startQ[1];
  assign startTrace = startQ[2];
  assign startReset = startQ[3];

  AST_ONE_START: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(startQ)); // R4
  AST_START_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (startQ != 4'b0) |-> busyQ); // R6
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> (!busyQ && $past(busyQ))); // R6
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> (!strb.instrWr && !strb.dataWr && !strb.dataStep)); // R8
  AST_RESERVED_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.instrWr && !opValid) |=> (!busyQ && startQ == 4'b0)); // R5
endmodule

// File: rtl/ccpRegs.sv
`timescale 1ns/1ps
module ccpRegs import ccpPkg::*; #(
  parameter int REG_COUNT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ccpStrobe_t        strb,
  input  logic              busy,
  input  logic [1:0]        hostSel,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata
);
  localparam int PTR_W = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(REG_COUNT - 1);

  logic [DATA_W-1:0] fileQ [REG_COUNT];
  logic [DATA_W-1:0] instrQ;
  logic [PTR_W-1:0]  ptrQ;

  for (genvar g = 0; g < REG_COUNT; g++) begin : gEntry
    localparam logic [DATA_W-1:0] RST_VAL =
      (g == REG_COUNT - 1) ? {DATA_W{1'b1}} :
      (g == REG_COUNT - 2) ? DATA_W'(16'h00FF) : '0;
    always_ff @(posedge clk) begin
      if (!rstN || strb.fileReset)
        fileQ[g] <= RST_VAL;
      else if (strb.dataWr && ptrQ == PTR_W'(g))
        fileQ[g] <= hostWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      ptrQ <= '0;
    else if (strb.ptrWr)
      ptrQ <= hostWdata[PTR_W-1:0];
    else if (strb.dataStep)
      ptrQ <= (ptrQ == LAST) ? '0 : ptrQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      instrQ <= INSTR_RST;
    else if (strb.instrWr)
      instrQ <= hostWdata;
  end

  always_comb begin
    case (hostSel)
      SEL_INSTR: hostRdata = instrQ;
      SEL_ADDR:  hostRdata = DATA_W'(ptrQ);
      SEL_DATA:  hostRdata = busy ? '0 : fileQ[ptrQ];
      default:   hostRdata = '0;
    endcase
  end

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dataStep && !strb.ptrWr) |=>
      (ptrQ == (($past(ptrQ) == LAST) ? '0 : $past(ptrQ) + 1'b1))); // R3
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.dataStep && !strb.ptrWr) |=> $stable(ptrQ)); // R8
  AST_INSTR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.instrWr) |=> $stable(instrQ)); // R8
  AST_BLOCKED_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busy && hostSel == SEL_DATA) |-> (hostRdata == '0)); // R8
endmodule

// File: rtl/ccpHostPort.sv
`timescale 1ns/1ps
module ccpHostPort import ccpPkg::*; #(
  parameter int REG_COUNT = 8,
  parameter int UPD_CYC   = 16,
  parameter int TRACE_CYC = 8,
  parameter int RST_CYC   = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  hostSel,
  input  logic        hostWr,
  input  logic        hostRd,
  input  logic [15:0] hostWdata,
  output logic [15:0] hostRdata,
  output logic        hostReady,
  output logic        busy,
  output logic        done,
  output logic        startMlse,
  output logic        startConv,
  output logic        startTrace,
  output logic        startReset
);
  ccpStrobe_t strb;

  ccpCtrl #(
    .UPD_CYC(UPD_CYC), .TRACE_CYC(TRACE_CYC), .RST_CYC(RST_CYC)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr),
    .hostRd(hostRd), .hostWdata(hostWdata), .strb(strb),
    .hostReady(hostReady), .busy(busy), .done(done),
    .startMlse(startMlse), .startConv(startConv),
    .startTrace(startTrace), .startReset(startReset)
  );

  ccpRegs #(.REG_COUNT(REG_COUNT)) i_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy),
    .hostSel(hostSel), .hostWdata(hostWdata), .hostRdata(hostRdata)
  );
endmodule

// File: tb/test_ccpHostPort.sv
`timescale 1ns/1ps
module test_ccpHostPort;
  localparam int N = 8;
  localparam logic [1:0] S_I = 2'd0, S_A = 2'd1, S_D = 2'd2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] hostSel = '0;
  logic hostWr = 1'b0, hostRd = 1'b0;
  logic [15:0] hostWdata = '0;
  logic [15:0] hostRdata;
  logic hostReady, busy, done, startMlse, startConv, startTrace, startReset;

  int total = 0, fails = 0;
  logic [15:0] lastRd;
  logic lastRdy;
  logic [15:0] model [N];

  always #2 clk = ~clk;

  ccpHostPort i_ccpHostPort (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr),
    .hostRd(hostRd), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .hostReady(hostReady), .busy(busy), .done(done),
    .startMlse(startMlse), .startConv(startConv),
    .startTrace(startTrace), .startReset(startReset)
  );

  function automatic logic [15:0] rv(int i);
    return (i == N-1) ? 16'hFFFF : (i == N-2) ? 16'h00FF : 16'h0000;
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one host cycle: drive at negedge, capture before the edge, release after
  task automatic acc(logic [1:0] s, logic w, logic r, logic [15:0] d);
    @(negedge clk);
    hostSel = s; hostWr = w; hostRd = r; hostWdata = d;
    #1;
    lastRd = hostRdata;
    lastRdy = hostReady;
    @(posedge clk);
    #1;
    hostWr = 1'b0; hostRd = 1'b0; hostSel = S_I; hostWdata = '0;
  endtask

  function automatic logic [3:0] strobes();
    return {startReset, startTrace, startConv, startMlse};
  endfunction

  // issue a command and measure its busy interval
  task automatic runOp(logic [15:0] code, int expDur, logic [3:0] expVec, string req);
    int n;
    acc(S_I, 1'b1, 1'b0, code);
    @(negedge clk);
    chk(req, {12'h0, strobes()}, {12'h0, expVec});
    n = 0;
    while (busy && n < 200) begin
      n++;
      @(negedge clk);
    end
    chk({req, " duration"}, 16'(n), 16'(expDur));
    if (expDur > 0) chk({req, " done"}, {15'h0, done}, 16'h1);
    else chk({req, " no done"}, {15'h0, done}, 16'h0);
    @(negedge clk);
    chk({req, " done width"}, {15'h0, done}, 16'h0);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    for (int i = 0; i < N; i++) model[i] = rv(i);

    // R1 reset state
    @(negedge clk);
    chk("R1 busy", {15'h0, busy}, 16'h0);
    chk("R1 done", {15'h0, done}, 16'h0);
    chk("R1 strobes", {12'h0, strobes()}, 16'h0);
    acc(S_I, 1'b0, 1'b1, '0); chk("R1 command", lastRd, 16'h0004);
    chk("R1 ready", {15'h0, lastRdy}, 16'h1);
    acc(S_A, 1'b0, 1'b1, '0); chk("R1 pointer", lastRd, 16'h0000);
    for (int i = 0; i < N; i++) begin
      acc(S_D, 1'b0, 1'b1, '0); chk("R1 file", lastRd, rv(i));
    end
    acc(S_A, 1'b0, 1'b1, '0); chk("R3 wrap after reads", lastRd, 16'h0000);

    // R2/R3 write sweep with wrap: N+3 writes from entry 0
    for (int i = 0; i < N + 3; i++) begin
      logic [15:0] v;
      v = 16'hA500 ^ 16'(i * 16'h1111);
      acc(S_D, 1'b1, 1'b0, v);
      model[i % N] = v;
    end
    acc(S_A, 1'b0, 1'b1, '0); chk("R3 pointer after writes", lastRd, 16'(3 % N));
    acc(S_A, 1'b1, 1'b0, 16'h0000);
    for (int i = 0; i < N; i++) begin
      acc(S_D, 1'b0, 1'b1, '0); chk("R2 readback", lastRd, model[i]);
    end
    acc(S_A, 1'b1, 1'b0, 16'(N - 1));
    acc(S_D, 1'b0, 1'b1, '0); chk("R2 last entry", lastRd, model[N-1]);
    acc(S_A, 1'b0, 1'b1, '0); chk("R3 wrap", lastRd, 16'h0000);

    // R4/R6 defined codes
    runOp(16'h0000, 16, 4'b0001, "R4 R6 mlse");
    runOp(16'h0001, 16, 4'b0010, "R4 R6 conv");
    runOp(16'h0002, 8,  4'b0100, "R4 R6 trace");

    // R5 reserved codes
    foreach (model[k]) begin end
    begin
      logic [15:0] codes [7];
      codes = '{16'h0003, 16'h0005, 16'h0006, 16'h0007, 16'h0010, 16'h8000, 16'hFFFF};
      for (int c = 0; c < 7; c++) begin
        runOp(codes[c], 0, 4'b0000, "R5 reserved");
        acc(S_I, 1'b0, 1'b1, '0); chk("R5 command stored", lastRd, codes[c]);
      end
    end

    // R8/R9 refused accesses during an update
    acc(S_A, 1'b1, 1'b0, 16'h0002);
    acc(S_I, 1'b1, 1'b0, 16'h0000);
    acc(S_D, 1'b0, 1'b1, '0);
    chk("R8 read ready", {15'h0, lastRdy}, 16'h0);
    chk("R8 read zero", lastRd, 16'h0000);
    acc(S_D, 1'b1, 1'b0, 16'hDEAD);
    chk("R8 write ready", {15'h0, lastRdy}, 16'h0);
    acc(S_I, 1'b1, 1'b0, 16'h0002);
    chk("R8 command ready", {15'h0, lastRdy}, 16'h0);
    acc(S_I, 1'b0, 1'b1, '0);
    chk("R9 command read", lastRd, 16'h0000);
    chk("R9 command read ready", {15'h0, lastRdy}, 16'h1);
    acc(S_A, 1'b0, 1'b1, '0);
    chk("R8 pointer not stepped", lastRd, 16'h0002);
    acc(S_A, 1'b1, 1'b0, 16'h0005);
    chk("R9 pointer write ready", {15'h0, lastRdy}, 16'h1);
    acc(S_A, 1'b0, 1'b1, '0);
    chk("R9 pointer readback", lastRd, 16'h0005);
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
    chk("R8 no late start", {15'h0, busy}, 16'h0);
    acc(S_I, 1'b0, 1'b1, '0); chk("R8 command kept", lastRd, 16'h0000);
    acc(S_D, 1'b0, 1'b1, '0); chk("R8 entry kept", lastRd, model[5]);
    acc(S_D, 1'b0, 1'b1, '0); chk("R8 other entry kept", lastRd, model[6]);

    // R9/R10 pointer write in last busy cycle, command in done cycle
    begin
      int n;
      acc(S_I, 1'b1, 1'b0, 16'h0001);
      @(negedge clk);
      n = 1;
      while (n < 16) begin @(negedge clk); n++; end
      chk("R6 last busy cycle", {15'h0, busy}, 16'h1);
      hostSel = S_A; hostWr = 1'b1; hostWdata = 16'h0003;
      @(posedge clk); #1;
      hostWr = 1'b0; hostSel = S_I; hostWdata = '0;
      @(negedge clk);
      chk("R6 done after 16", {15'h0, done}, 16'h1);
      hostSel = S_I; hostWr = 1'b1; hostWdata = 16'h0002;
      #1 chk("R10 ready in done cycle", {15'h0, hostReady}, 16'h1);
      @(posedge clk); #1;
      hostWr = 1'b0; hostWdata = '0;
      @(negedge clk);
      chk("R10 trace strobe", {12'h0, strobes()}, 16'h0004);
      n = 0;
      while (busy && n < 200) begin n++; @(negedge clk); end
      chk("R10 trace duration", 16'(n), 16'd8);
      acc(S_A, 1'b0, 1'b1, '0); chk("R9 pointer kept over done", lastRd, 16'h0003);
    end

    // R7 reinitialise
    acc(S_A, 1'b1, 1'b0, 16'h0000);
    for (int i = 0; i < N; i++) acc(S_D, 1'b1, 1'b0, 16'h1234 + 16'(i));
    acc(S_A, 1'b1, 1'b0, 16'h0001);
    runOp(16'h0004, 1, 4'b1000, "R4 R6 reinit");
    acc(S_A, 1'b0, 1'b1, '0); chk("R7 pointer kept", lastRd, 16'h0001);
    acc(S_I, 1'b0, 1'b1, '0); chk("R7 command", lastRd, 16'h0004);
    acc(S_A, 1'b1, 1'b0, 16'h0000);
    for (int i = 0; i < N; i++) begin
      acc(S_D, 1'b0, 1'b1, '0); chk("R7 file restored", lastRd, rv(i));
    end

    finishRun();
  end
endmodule